// File: doc/BRIEF.md
# Pixel Clock Parameter Search

This block turns a requested pixel period, given in picoseconds, into a three-field setting for a clock synthesizer: a multiplier `k`, a divider `n` and a post-scaler exponent `p`. A request is first raised to a floor of 5000 ps. It is then checked against an upper limit, and a post-scaler is picked from its size. The engine then tries every multiplier from 1 to 31 in turn. For each one it runs a multi-cycle restoring division and keeps the candidate that leaves the smallest remainder. One command is accepted at a time, and a one-cycle `done` pulse marks its completion.

The same engine also runs in a reverse direction. With `rev_i` high at start, it takes the setting it holds and computes the period that setting produces. That computation reuses the same divider. Shipping the setting to the synthesizer is left to surrounding logic.

Top module: `pclk_search`

## Requirements
- R1: After a synchronous reset, `done_o` and `err_o` are 0, and `k_o`, `n_o`, `p_o` and `period_o` are all 0.
- R2: A request below 5000 ps is handled exactly as a request of 5000 ps.
- R3: After clamping, a request above 2048128 ps (256016 shifted left by 3) completes with `err_o` = 1 and with `k_o`, `n_o` and `p_o` all 0.
- R4: Let e be the clamped request. `p_o` is 3 when e*16 < 256016, and 2 otherwise.
- R5: For a search, l = e << p. The result satisfies `n_o` = floor(256016*k/l). It is the k in 1..31 with 1 <= n <= 127 whose remainder (256016*k mod l) is smallest. On equal remainders the lowest k is kept.
- R6: When no k gives a quotient in 1..127, the search completes with `err_o` = 1 and `k_o`, `n_o` and `p_o` all 0. This is the case, for example, for a request of 2000000 ps.
- R7: A reverse command (`rev_i` = 1) with a held `n_o` other than 0 completes with `err_o` = 0 and `period_o` = ((256016*k_o)/n_o) >> p_o, using integer division.
- R8: A reverse command while the held `n_o` is 0 completes with `err_o` = 1 and `period_o` = 0.
- R9: Every accepted command produces exactly one `done_o` pulse, one cycle wide. The pulse comes no more than 31*35+8 cycles after the command is accepted.
- R10: A `start_i` that arrives while a command is in progress is ignored. It changes neither the result of the running command nor adds a `done_o` pulse.
- R11: A `start_i` in the same cycle as a `done_o` pulse is accepted as a new command.
- R12: A search leaves `period_o` unchanged. A reverse command leaves `k_o`, `n_o` and `p_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Command request, taken when the engine is idle |
| rev_i | input | 1 | 0: search for a setting; 1: compute the period of the held setting |
| req_ps_i | input | 32 | Requested pixel period in picoseconds |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Error flag of the last completed command |
| k_o | output | 5 | Multiplier of the held setting |
| n_o | output | 7 | Divider of the held setting |
| p_o | output | 2 | Post-scaler exponent of the held setting |
| period_o | output | 32 | Period computed by the last reverse command |

## Verification
Two things can fall into the same cycle: the `done_o` pulse that ends one command and the `start_i` of the next. The bench provokes this by raising `start_i` in the very cycle where it first sees `done_o`. It does so both for a following search and for a following reverse command. It then judges the second result against the reference model, so a dropped or merged command shows up as a wrong or missing result. The mirror case is a `start_i` that lands in the middle of a search. The bench issues such starts with a different request and then watches for more than a full search time, so that any extra pulse or altered setting is reported.

// File: rtl/pclk_pkg.sv
package pclk_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_LAUNCH,
    ST_WAIT,
    ST_DECIDE
  } pclk_state_t;
endpackage

// File: rtl/pclk_rdiv.sv
module pclk_rdiv #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         done_o,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o
);
  localparam int CW = $clog2(W + 1);

  logic         busy_q, done_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0] dvs_q, dvd_q, rem_q, quo_q;
  logic [W:0]   shifted, diff;

  always_comb begin
    shifted = {rem_q, quo_q[W-1]};
    diff    = shifted - {1'b0, dvs_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      dvs_q  <= '0;
      dvd_q  <= '0;
      rem_q  <= '0;
      quo_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        busy_q <= 1'b1;
        cnt_q  <= CW'(W);
        dvs_q  <= divisor_i;
        dvd_q  <= dividend_i;
        quo_q  <= dividend_i;
        rem_q  <= '0;
      end else if (busy_q) begin
        if (!diff[W]) begin
          rem_q <= diff[W-1:0];
          quo_q <= {quo_q[W-2:0], 1'b1};
        end else begin
          rem_q <= shifted[W-1:0];
          quo_q <= {quo_q[W-2:0], 1'b0};
        end
        cnt_q <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign quo_o  = quo_q;
  assign rem_o  = rem_q;

  // R5
  div_exact_chk: assert property (@(posedge clk) disable iff (rst)
    (done_q && dvs_q != '0) |->
      (((2*W)'(quo_q) * (2*W)'(dvs_q) + (2*W)'(rem_q)) == (2*W)'(dvd_q)) && (rem_q < dvs_q));
endmodule

// File: rtl/pclk_prescale.sv
module pclk_prescale #(
  parameter int W         = 32,
  parameter int BASE      = 256016,
  parameter int MIN_PS    = 5000,
  parameter int MAX_SHIFT = 3
) (
  input  logic [W-1:0] req_i,
  output logic         too_big_o,
  output logic [1:0]   ps_o,
  output logic [W-1:0] l_o
);
  localparam logic [W-1:0] REQ_LIMIT = W'(BASE) << MAX_SHIFT;

  logic [W-1:0] eff;
  logic [W+3:0] scaled16;

  always_comb begin
    eff       = (req_i < W'(MIN_PS)) ? W'(MIN_PS) : req_i;
    too_big_o = eff > REQ_LIMIT;
    scaled16  = {eff, 4'b0000};
    ps_o      = (scaled16 < (W+4)'(BASE)) ? 2'd3 : 2'd2;
    l_o       = eff << ps_o;
  end
endmodule

// File: rtl/pclk_search.sv
module pclk_search #(
  parameter int W         = 32,
  parameter int BASE      = 256016,
  parameter int KMAX      = 31,
  parameter int NMAX      = 128,
  parameter int MIN_PS    = 5000,
  parameter int MAX_SHIFT = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start_i,
  input  logic                      rev_i,
  input  logic [W-1:0]              req_ps_i,
  output logic                      done_o,
  output logic                      err_o,
  output logic [$clog2(KMAX+1)-1:0] k_o,
  output logic [$clog2(NMAX)-1:0]   n_o,
  output logic [1:0]                p_o,
  output logic [W-1:0]              period_o
);
  import pclk_pkg::*;

  localparam int KW         = $clog2(KMAX + 1);
  localparam int NW         = $clog2(NMAX);
  localparam int BUSY_LIMIT = KMAX * (W + 3) + 8;
  localparam int CCW        = $clog2(BUSY_LIMIT + 2);

  pclk_state_t  st_q;
  logic         rev_q;
  logic [W-1:0] req_q, l_q, best_rem_q;
  logic [KW-1:0] kc_q, best_k_q;
  logic [NW-1:0] best_n_q;
  logic [1:0]   ps_q;

  logic         too_big;
  logic [1:0]   ps_w;
  logic [W-1:0] l_w;

  logic         div_start, div_done;
  logic [W-1:0] dvd_w, dvs_w, quo_w, rem_w;
  logic [KW-1:0] sel_k;
  logic         accept;

  pclk_prescale #(
    .W(W), .BASE(BASE), .MIN_PS(MIN_PS), .MAX_SHIFT(MAX_SHIFT)
  ) u_pre (
    .req_i(req_q), .too_big_o(too_big), .ps_o(ps_w), .l_o(l_w)
  );

  always_comb begin
    sel_k     = rev_q ? k_o : kc_q;
    dvd_w     = W'(BASE) * W'(sel_k);
    dvs_w     = rev_q ? W'(n_o) : l_q;
    div_start = (st_q == ST_LAUNCH);
    accept    = (quo_w != '0) && (quo_w < W'(NMAX)) && (rem_w < best_rem_q);
  end

  pclk_rdiv #(.W(W)) u_div (
    .clk(clk), .rst(rst), .start_i(div_start),
    .dividend_i(dvd_w), .divisor_i(dvs_w),
    .done_o(div_done), .quo_o(quo_w), .rem_o(rem_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      rev_q      <= 1'b0;
      req_q      <= '0;
      l_q        <= '0;
      best_rem_q <= '0;
      kc_q       <= '0;
      best_k_q   <= '0;
      best_n_q   <= '0;
      ps_q       <= '0;
      done_o     <= 1'b0;
      err_o      <= 1'b0;
      k_o        <= '0;
      n_o        <= '0;
      p_o        <= '0;
      period_o   <= '0;
    end else begin
      done_o <= 1'b0;
      case (st_q)
        ST_IDLE: if (start_i) begin
          rev_q <= rev_i;
          if (rev_i) begin
            if (n_o == '0) begin
              done_o   <= 1'b1;
              err_o    <= 1'b1;
              period_o <= '0;
            end else begin
              st_q <= ST_LAUNCH;
            end
          end else begin
            req_q <= req_ps_i;
            st_q  <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (too_big) begin
            done_o <= 1'b1;
            err_o  <= 1'b1;
            k_o    <= '0;
            n_o    <= '0;
            p_o    <= '0;
            st_q   <= ST_IDLE;
          end else begin
            l_q        <= l_w;
            ps_q       <= ps_w;
            kc_q       <= KW'(1);
            best_rem_q <= l_w;
            best_k_q   <= '0;
            best_n_q   <= '0;
            st_q       <= ST_LAUNCH;
          end
        end
        ST_LAUNCH: st_q <= ST_WAIT;
        ST_WAIT: if (div_done) begin
          if (rev_q) begin
            period_o <= quo_w >> p_o;
            err_o    <= 1'b0;
            done_o   <= 1'b1;
            st_q     <= ST_IDLE;
          end else begin
            if (accept) begin
              best_k_q   <= kc_q;
              best_n_q   <= NW'(quo_w);
              best_rem_q <= rem_w;
            end
            if (kc_q == KW'(KMAX)) begin
              st_q <= ST_DECIDE;
            end else begin
              kc_q <= kc_q + KW'(1);
              st_q <= ST_LAUNCH;
            end
          end
        end
        ST_DECIDE: begin
          done_o <= 1'b1;
          st_q   <= ST_IDLE;
          if (best_k_q == '0 || best_n_q == '0) begin
            err_o <= 1'b1;
            k_o   <= '0;
            n_o   <= '0;
            p_o   <= '0;
          end else begin
            err_o <= 1'b0;
            k_o   <= best_k_q;
            n_o   <= best_n_q;
            p_o   <= ps_q;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // Cycle counter for the completion bound check
  logic [CCW-1:0] busy_cyc_q;
  always_ff @(posedge clk) begin
    if (rst || st_q == ST_IDLE) busy_cyc_q <= '0;
    else if (busy_cyc_q != '1)  busy_cyc_q <= busy_cyc_q + CCW'(1);
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  // R9
  run_bound_chk: assert property (@(posedge clk) disable iff (rst)
    busy_cyc_q <= CCW'(BUSY_LIMIT));
  // R6
  err_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && err_o && !rev_q) |-> (k_o == '0 && n_o == '0 && p_o == '0));
  // R5
  n_range_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && !err_o && !rev_q) |-> (n_o != '0 && k_o != '0 && p_o >= 2'd2));
  // R3
  too_big_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_CHECK && too_big) |=> (done_o && err_o));
  // R10
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q != ST_IDLE && start_i) |=> ($stable(req_q) && $stable(rev_q)));
endmodule

// File: tb/pclk_search_test.sv
module pclk_search_test;
  localparam int LIMIT = 31 * 35 + 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic        rev_i = 1'b0;
  logic [31:0] req_ps_i = '0;
  logic        done_o, err_o;
  logic [4:0]  k_o;
  logic [6:0]  n_o;
  logic [1:0]  p_o;
  logic [31:0] period_o;

  int n_chk = 0;
  int n_bad = 0;
  int sk = 0, sn = 0, sp = 0;

  always #5 clk = ~clk;

  pclk_search uut (
    .clk(clk), .rst(rst), .start_i(start_i), .rev_i(rev_i), .req_ps_i(req_ps_i),
    .done_o(done_o), .err_o(err_o), .k_o(k_o), .n_o(n_o), .p_o(p_o), .period_o(period_o)
  );

  task automatic chk(input bit ok, input string tag, input string act, input string exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%s expected=%s", tag, act, exp);
    end
  endtask

  function automatic void model(input longint req, output int k, output int n,
                                output int p, output bit err);
    longint eff, l, best, m, q, r;
    int pp, bk, bn;
    k = 0; n = 0; p = 0; err = 1'b0; bk = 0; bn = 0;
    eff = (req < 5000) ? 5000 : req;
    if (eff > 256016 * 8) begin
      err = 1'b1;
      return;
    end
    pp = (eff * 16 < 256016) ? 3 : 2;
    l = eff << pp;
    best = l;
    for (int kk = 1; kk < 32; kk++) begin
      m = 256016 * kk;
      q = m / l;
      r = m % l;
      if (q != 0 && q < 128 && r < best) begin
        bk = kk; bn = int'(q); best = r;
      end
    end
    if (bk == 0 || bn == 0) err = 1'b1;
    else begin k = bk; n = bn; p = pp; end
  endfunction

  task automatic send(input bit rev, input logic [31:0] req);
    start_i = 1'b1; rev_i = rev; req_ps_i = req;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!done_o && cyc < 3000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic check_search(input logic [31:0] req, input string tag, input logic [31:0] per0);
    int ek, en, ep;
    bit ee;
    model(req, ek, en, ep, ee);
    chk(done_o === 1'b1, "R9 done", $sformatf("%b", done_o), "1");
    chk(err_o === ee, tag, $sformatf("err=%b req=%0d", err_o, req), $sformatf("err=%b", ee));
    chk(k_o == ek && n_o == en && p_o == ep, tag,
        $sformatf("k=%0d n=%0d p=%0d req=%0d", k_o, n_o, p_o, req),
        $sformatf("k=%0d n=%0d p=%0d", ek, en, ep));
    chk(period_o == per0, "R12 period kept", $sformatf("%0d", period_o), $sformatf("%0d", per0));
    sk = ek; sn = en; sp = ep;
  endtask

  task automatic run_search(input logic [31:0] req, input string tag);
    int cyc;
    logic [31:0] per0;
    per0 = period_o;
    send(1'b0, req);
    wait_done(cyc);
    chk(cyc <= LIMIT, "R9 bound", $sformatf("%0d", cyc), $sformatf("<=%0d", LIMIT));
    check_search(req, tag, per0);
    @(negedge clk);
    chk(done_o === 1'b0, "R9 one-cycle", $sformatf("%b", done_o), "0");
  endtask

  task automatic check_rev(input string tag);
    longint ep;
    bit ee;
    ee = (sn == 0);
    ep = ee ? 0 : ((longint'(256016) * sk) / sn) >>> sp;
    chk(done_o === 1'b1, "R9 done", $sformatf("%b", done_o), "1");
    chk(err_o === ee && period_o == ep, tag,
        $sformatf("err=%b period=%0d", err_o, period_o), $sformatf("err=%b period=%0d", ee, ep));
    chk(k_o == sk && n_o == sn && p_o == sp, "R12 setting kept",
        $sformatf("k=%0d n=%0d p=%0d", k_o, n_o, p_o), $sformatf("k=%0d n=%0d p=%0d", sk, sn, sp));
  endtask

  task automatic run_rev(input string tag);
    int cyc;
    send(1'b1, 32'd0);
    wait_done(cyc);
    check_rev(tag);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    int cyc, ek, en, ep, extra;
    bit ee;
    logic [31:0] r, per0;
    void'($urandom(32'd7151));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(done_o === 1'b0 && err_o === 1'b0 && k_o == 0 && n_o == 0 && p_o == 0 && period_o == 0,
        "R1 reset", $sformatf("d=%b e=%b k=%0d n=%0d p=%0d per=%0d", done_o, err_o, k_o, n_o, p_o, period_o),
        "all zero");
    @(negedge clk);

    // R8 reverse with no stored setting
    run_rev("R8 empty setting");

    // R2 clamp, R4 post-scaler boundary, R3 and R6 errors
    run_search(32'd0, "R2 zero request");
    run_search(32'd4999, "R2 below floor");
    run_search(32'd5000, "R2 at floor");
    run_rev("R7 reverse");
    run_search(32'd16000, "R4 p=3 edge");
    chk(p_o == 2'd3, "R4 p at 16000", $sformatf("%0d", p_o), "3");
    run_search(32'd16001, "R4 p=2 edge");
    chk(p_o == 2'd2, "R4 p at 16001", $sformatf("%0d", p_o), "2");
    run_rev("R7 reverse");
    run_search(32'd39722, "R5 typical");
    run_search(32'd2000000, "R6 no candidate");
    run_rev("R8 after error");
    run_search(32'd2048128, "R6 at limit");
    run_search(32'd2048129, "R3 over limit");
    run_search(32'hFFFF_FFFF, "R3 max request");

    // R10 starts while busy are ignored
    send(1'b0, 32'd25000);
    repeat (5) @(negedge clk);
    send(1'b0, 32'd90000);
    send(1'b1, 32'd0);
    per0 = period_o;
    wait_done(cyc);
    check_search(32'd25000, "R10 busy start ignored", per0);
    extra = 0;
    for (int i = 0; i < 1200; i++) begin
      @(negedge clk);
      if (done_o) extra++;
    end
    chk(extra == 0, "R10 no extra done", $sformatf("%0d", extra), "0");

    // R11 start in the done cycle
    send(1'b0, 32'd12000);
    wait_done(cyc);
    per0 = period_o;
    check_search(32'd12000, "R11 first", per0);
    send(1'b0, 32'd70000);
    wait_done(cyc);
    check_search(32'd70000, "R11 back-to-back search", per0);
    send(1'b1, 32'd0);
    wait_done(cyc);
    check_rev("R11 back-to-back reverse");
    @(negedge clk);

    // R5 random requests
    for (int i = 0; i < 36; i++) begin
      case (i % 3)
        0: r = $urandom_range(40000, 0);
        1: r = $urandom_range(2100000, 16000);
        default: r = $urandom;
      endcase
      run_search(r, "R5 random");
      if (i % 4 == 0) run_rev("R7 random reverse");
    end

    model(32'd0, ek, en, ep, ee);
    summary();
    $finish;
  end
endmodule